// File: doc/BRIEF.md
# Receive Character Queue with Trigger Interrupt, Idle Timeout and Hysteresis Flow Control

This block sits between a serial receiver and the host side of a UART-style port. Each received character arrives as one 11-bit entry: eight data bits plus three error flags captured by the deserializer. The entries are kept in a 64-deep first-in, first-out queue. The entry at the head drives the read port. Its error flags appear as line status, so the status always describes the byte the host is about to take.

The block raises a data-ready interrupt. In queue mode it fires once the fill level reaches a programmable trigger. In single-character mode it fires for every character. An idle timer counts bit-time ticks. It delivers a remainder that never reaches the trigger: after four character times plus twelve bit times with no queue activity, it raises a timeout interrupt. The character time follows a 2-bit length field. An active-low request-to-send style output throttles the remote transmitter. It goes high when the fill level climbs to the trigger plus a hysteresis band. It returns low once the fill level drains to the trigger minus the band.

Top module: `rx_char_queue`

## Requirements
- R1: After reset the queue is empty. In queue mode (`fifo_mode`=1) it holds up to 64 entries, and entries leave in the order they were written.
- R2: `rd_data` is bits [7:0] and `head_err` is bits [10:8] of the head entry. Both read zero when the queue is empty. After a read strobe they show the next entry in the cycle after the clock edge.
- R3: In queue mode, `rx_ready_irq` is high exactly while `fill_level` is at least `trig_level`. A trigger of 0 acts as 1, and a trigger above 64 acts as 64.
- R4: In single-character mode (`fifo_mode`=0) the queue holds one entry, and `rx_ready_irq` is high whenever that entry is present.
- R5: With `irq_en`=0, both `rx_ready_irq` and `rx_tmo_irq` stay low.
- R6: While the queue is non-empty and below the effective trigger, `rx_tmo_irq` rises after 4×(`char_len`+7)+12 `bit_tick` pulses with no accepted write and no read. That is 40 ticks for `char_len`=0 and 52 ticks for `char_len`=3.
- R7: Every accepted write or read restarts the idle timer. `rx_tmo_irq` is low while the queue is empty.
- R8: With flow control active, `rts_n` goes high in the cycle after `fill_level` reaches `trig_level`+`hyst_band`. It goes low in the cycle after `fill_level` falls to `trig_level`−`hyst_band` (floor 0). Between the two thresholds it keeps its value.
- R9: Flow control is active only when `flow_feat_en` and `flow_modem_en` are both 1. Otherwise `rts_n` is low from the next cycle.
- R10: A write while the queue is at capacity is dropped, and a read in the same cycle does not make room for it. The drop sets `overrun`, which stays set until a `status_rd` pulse. A set in the same cycle as a clear wins.
- R11: A read strobe on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_entry | input | 11 | Entry: error flags [10:8], data [7:0] |
| rd_en | input | 1 | Read strobe, pops the head entry |
| status_rd | input | 1 | Status read, clears the overrun flag |
| fifo_mode | input | 1 | 1 = 64-entry queue, 0 = single character |
| trig_level | input | 7 | Interrupt and flow trigger level |
| hyst_band | input | 7 | Flow-control hysteresis band |
| char_len | input | 2 | Word length code (5 to 8 data bits) |
| bit_tick | input | 1 | One pulse per bit time |
| irq_en | input | 1 | Receive interrupt enable |
| flow_feat_en | input | 1 | Enhanced flow feature enable |
| flow_modem_en | input | 1 | Modem flow control enable |
| rd_data | output | 8 | Data of head entry |
| head_err | output | 3 | Error flags of head entry |
| fill_level | output | 7 | Entries held |
| rx_ready_irq | output | 1 | Data-ready interrupt |
| rx_tmo_irq | output | 1 | Idle timeout interrupt |
| overrun | output | 1 | Sticky overrun flag |
| rts_n | output | 1 | Active-low flow-control output |

## Verification
The queue is driven with several write/read patterns, and each one separates different faults.
- Short interleaved bursts against a trigger of 4 separate a trigger compared with `>` from one compared with `>=`. They also show whether the head flags follow the popped entry.
- A fill to capacity and beyond, with data equal to the index, shows a dropped write and a misordered pointer.
- Draining through the 56/40 hysteresis window separates holding behaviour from a plain comparator.
- Idle waits at two word lengths, with and without an intervening write, pin the timeout count to the exact tick, so an off-by-one limit or a timer that fails to restart is caught.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    parameter int unsigned RXQ_DEPTH = 64;
    parameter int unsigned RXQ_DW    = 8;
    parameter int unsigned RXQ_EW    = 3;
    localparam int unsigned RXQ_TMO_W = 8;
    localparam int unsigned RXQ_IDLE_EXTRA = 12;
    localparam int unsigned RXQ_IDLE_CHARS = 4;
    localparam int unsigned RXQ_FRAME_BASE = 7;

    typedef enum logic {
        FLOW_GO   = 1'b0,
        FLOW_HOLD = 1'b1
    } flow_state_e;

    typedef enum logic [1:0] {
        Q_NONE = 2'b00,
        Q_POP  = 2'b01,
        Q_PUSH = 2'b10,
        Q_BOTH = 2'b11
    } q_op_e;

    // bits per character: start + (5..8) data + stop
    function automatic logic [RXQ_TMO_W-1:0] rxq_idle_limit(input logic [1:0] len_code);
        int unsigned bits;
        bits = 32'(len_code) + RXQ_FRAME_BASE;
        return RXQ_TMO_W'(RXQ_IDLE_CHARS * bits + RXQ_IDLE_EXTRA);
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned WIDTH = RXQ_DW + RXQ_EW,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_entry,
    input  logic             rd_en,
    input  logic             status_rd,
    input  logic [CW-1:0]    cap,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    fill,
    output logic             pushed,
    output logic             popped,
    output logic             ovr
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    q_op_e            op;

    assign pushed = wr_en && (fill < cap);
    assign popped = rd_en && (fill != '0);
    assign op     = q_op_e'({pushed, popped});

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (pushed) begin
            mem[wp] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (pushed) wp <= bump(wp);
            if (popped) rp <= bump(rp);
            case (op)
                Q_PUSH:  fill <= fill + CW'(1);
                Q_POP:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr <= 1'b0;
        end else if (wr_en && !pushed) begin
            ovr <= 1'b1;
        end else if (status_rd) begin
            ovr <= 1'b0;
        end
    end

    assign head = (fill == '0) ? '0 : mem[rp];
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       activity,
    input  logic       empty,
    input  logic [1:0] len_code,
    output logic       expired
);
    logic [RXQ_TMO_W-1:0] cnt;
    logic [RXQ_TMO_W-1:0] limit;

    assign limit = rxq_idle_limit(len_code);

    always_ff @(posedge clk) begin
        if (rst || activity || empty) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (tick && !expired) begin
            if (cnt == limit - RXQ_TMO_W'(1)) begin
                expired <= 1'b1;
            end else begin
                cnt <= cnt + RXQ_TMO_W'(1);
            end
        end
    end
endmodule

// File: rtl/rxq_flow.sv
module rxq_flow
    import rxq_pkg::*;
#(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] trig,
    input  logic [CW-1:0] band,
    output logic          hold_n
);
    logic [CW:0] hi_mark;
    logic [CW:0] lo_mark;
    flow_state_e state;

    assign hi_mark = {1'b0, trig} + {1'b0, band};
    assign lo_mark = (trig > band) ? {1'b0, trig - band} : '0;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state <= FLOW_GO;
        end else if ({1'b0, fill} >= hi_mark) begin
            state <= FLOW_HOLD;
        end else if ({1'b0, fill} <= lo_mark) begin
            state <= FLOW_GO;
        end
    end

    assign hold_n = (state == FLOW_HOLD);
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned DW    = RXQ_DW,
    parameter int unsigned EW    = RXQ_EW,
    localparam int unsigned CW   = $clog2(DEPTH + 1),
    localparam int unsigned WW   = DW + EW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_entry,
    input  logic          rd_en,
    input  logic          status_rd,
    input  logic          fifo_mode,
    input  logic [CW-1:0] trig_level,
    input  logic [CW-1:0] hyst_band,
    input  logic [1:0]    char_len,
    input  logic          bit_tick,
    input  logic          irq_en,
    input  logic          flow_feat_en,
    input  logic          flow_modem_en,
    output logic [DW-1:0] rd_data,
    output logic [EW-1:0] head_err,
    output logic [CW-1:0] fill_level,
    output logic          rx_ready_irq,
    output logic          rx_tmo_irq,
    output logic          overrun,
    output logic          rts_n
);
    logic [CW-1:0] cap;
    logic [CW-1:0] eff_trig;
    logic [WW-1:0] head;
    logic          pushed, popped, expired;

    assign cap = fifo_mode ? CW'(DEPTH) : CW'(1);

    always_comb begin
        if (!fifo_mode || trig_level == '0) begin
            eff_trig = CW'(1);
        end else if (trig_level > CW'(DEPTH)) begin
            eff_trig = CW'(DEPTH);
        end else begin
            eff_trig = trig_level;
        end
    end

    rxq_store #(.DEPTH(DEPTH), .WIDTH(WW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_entry  (wr_entry),
        .rd_en     (rd_en),
        .status_rd (status_rd),
        .cap       (cap),
        .head      (head),
        .fill      (fill_level),
        .pushed    (pushed),
        .popped    (popped),
        .ovr       (overrun)
    );

    rxq_timeout u_idle (
        .clk      (clk),
        .rst      (rst),
        .tick     (bit_tick),
        .activity (pushed || popped),
        .empty    (fill_level == '0),
        .len_code (char_len),
        .expired  (expired)
    );

    rxq_flow #(.CW(CW)) u_flow (
        .clk    (clk),
        .rst    (rst),
        .enable (flow_feat_en && flow_modem_en),
        .fill   (fill_level),
        .trig   (trig_level),
        .band   (hyst_band),
        .hold_n (rts_n)
    );

    assign rd_data      = head[DW-1:0];
    assign head_err     = head[WW-1:DW];
    assign rx_ready_irq = irq_en && (fill_level >= eff_trig);
    assign rx_tmo_irq   = irq_en && expired && (fill_level < eff_trig);
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          status_rd,
    input logic          fifo_mode,
    input logic          irq_en,
    input logic          flow_feat_en,
    input logic          flow_modem_en,
    input logic [CW-1:0] trig_level,
    input logic [CW-1:0] hyst_band,
    input logic [CW-1:0] fill_level,
    input logic          rx_ready_irq,
    input logic          rx_tmo_irq,
    input logic          overrun,
    input logic          rts_n
);
    logic [CW-1:0] lim;
    logic [CW:0]   hi_t, lo_t;
    logic          fc_on;
    assign lim   = fifo_mode ? CW'(DEPTH) : CW'(1);
    assign hi_t  = {1'b0, trig_level} + {1'b0, hyst_band};
    assign lo_t  = (trig_level > hyst_band) ? {1'b0, trig_level - hyst_band} : '0;
    assign fc_on = flow_feat_en && flow_modem_en;

    a_r1_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill_level <= CW'(DEPTH));
    a_r11_empty_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && fill_level == '0) |=> fill_level == '0);
    a_r1_pop_count: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && fill_level != '0) |=> fill_level == $past(fill_level) - CW'(1));
    a_r10_overrun_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fill_level >= lim) |=> overrun);
    a_r10_overrun_clear: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !wr_en) |=> !overrun);
    a_r5_irq_gate: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> (!rx_ready_irq && !rx_tmo_irq));
    a_r7_empty_no_tmo: assert property (@(posedge clk) disable iff (rst)
        fill_level == '0 |-> !rx_tmo_irq);
    a_r7_read_restart: assert property (@(posedge clk) disable iff (rst)
        (rd_en && fill_level != '0) |=> !rx_tmo_irq);
    a_r9_flow_off: assert property (@(posedge clk) disable iff (rst)
        !fc_on |=> !rts_n);
    a_r8_flow_hold: assert property (@(posedge clk) disable iff (rst)
        (fc_on && {1'b0, fill_level} > lo_t && {1'b0, fill_level} < hi_t)
        |=> (rts_n == $past(rts_n)));
endmodule

bind rx_char_queue rxq_checker #(.DEPTH(DEPTH)) u_rxq_checker (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .status_rd     (status_rd),
    .fifo_mode     (fifo_mode),
    .irq_en        (irq_en),
    .flow_feat_en  (flow_feat_en),
    .flow_modem_en (flow_modem_en),
    .trig_level    (trig_level),
    .hyst_band     (hyst_band),
    .fill_level    (fill_level),
    .rx_ready_irq  (rx_ready_irq),
    .rx_tmo_irq    (rx_tmo_irq),
    .overrun       (overrun),
    .rts_n         (rts_n)
);

// File: tb/rx_char_queue_test.sv
`timescale 1ns/1ps
module rx_char_queue_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en, status_rd, fifo_mode, bit_tick, irq_en;
    logic        flow_feat_en, flow_modem_en;
    logic [10:0] wr_entry;
    logic [6:0]  trig_level, hyst_band;
    logic [1:0]  char_len;
    logic [7:0]  rd_data;
    logic [2:0]  head_err;
    logic [6:0]  fill_level;
    logic        rx_ready_irq, rx_tmo_irq, overrun, rts_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rx_char_queue uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_entry(wr_entry), .rd_en(rd_en),
        .status_rd(status_rd), .fifo_mode(fifo_mode), .trig_level(trig_level),
        .hyst_band(hyst_band), .char_len(char_len), .bit_tick(bit_tick),
        .irq_en(irq_en), .flow_feat_en(flow_feat_en), .flow_modem_en(flow_modem_en),
        .rd_data(rd_data), .head_err(head_err), .fill_level(fill_level),
        .rx_ready_irq(rx_ready_irq), .rx_tmo_irq(rx_tmo_irq), .overrun(overrun),
        .rts_n(rts_n)
    );

    // vector: [31:30] op (0 write, 1 read), [29:19] entry, [18:12] fill, [11] irq, [10:0] head
    localparam logic [31:0] VEC [11] = '{
        {2'd0, 11'h1A5, 7'd1, 1'b0, 11'h1A5},
        {2'd0, 11'h23C, 7'd2, 1'b0, 11'h1A5},
        {2'd0, 11'h000, 7'd3, 1'b0, 11'h1A5},
        {2'd0, 11'h7FF, 7'd4, 1'b1, 11'h1A5},
        {2'd1, 11'h000, 7'd3, 1'b0, 11'h23C},
        {2'd1, 11'h000, 7'd2, 1'b0, 11'h000},
        {2'd0, 11'h412, 7'd3, 1'b0, 11'h000},
        {2'd1, 11'h000, 7'd2, 1'b0, 11'h7FF},
        {2'd1, 11'h000, 7'd1, 1'b0, 11'h412},
        {2'd1, 11'h000, 7'd0, 1'b0, 11'h000},
        {2'd1, 11'h000, 7'd0, 1'b0, 11'h000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; status_rd = 1'b0; wr_entry = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_wr(input logic [10:0] e);
        @(negedge clk);
        wr_en = 1'b1; wr_entry = e;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        fifo_mode = 1'b1; trig_level = 7'd4; hyst_band = 7'd0; char_len = 2'd0;
        bit_tick = 1'b0; irq_en = 1'b1; flow_feat_en = 1'b0; flow_modem_en = 1'b0;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 reset fill", 32'(fill_level), 0);
        chk("R1 reset irq", 32'(rx_ready_irq), 0);
        chk("R10 reset overrun", 32'(overrun), 0);
        chk("R9 reset rts_n", 32'(rts_n), 0);
        chk("R2 reset head", 32'({head_err, rd_data}), 0);

        // vector walk: trigger 4
        for (int k = 0; k < 11; k++) begin
            if (VEC[k][31:30] == 2'd0) do_wr(VEC[k][29:19]);
            else do_rd();
            chk(k == 10 ? "R11 empty read fill" : "R1 fill", 32'(fill_level), 32'(VEC[k][18:12]));
            chk("R3 ready irq", 32'(rx_ready_irq), 32'(VEC[k][11]));
            chk("R2 head entry", 32'({head_err, rd_data}), 32'(VEC[k][10:0]));
        end

        // full queue, overrun, hysteresis
        do_reset();
        trig_level = 7'd48; hyst_band = 7'd8; flow_feat_en = 1'b1; flow_modem_en = 1'b1;
        for (int i = 0; i < 47; i++) do_wr({3'(i % 8), 8'(i)});
        chk("R3 below trigger 48", 32'(rx_ready_irq), 0);
        do_wr({3'(47 % 8), 8'(47)});
        chk("R3 at trigger 48", 32'(rx_ready_irq), 1);
        for (int i = 48; i < 55; i++) do_wr({3'(i % 8), 8'(i)});
        @(negedge clk);
        chk("R8 rts_n at 55", 32'(rts_n), 0);
        do_wr({3'(55 % 8), 8'(55)});
        @(negedge clk);
        chk("R8 rts_n at 56", 32'(rts_n), 1);
        flow_modem_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 modem enable off", 32'(rts_n), 0);
        flow_modem_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 both enables on", 32'(rts_n), 1);
        for (int i = 56; i < 64; i++) do_wr({3'(i % 8), 8'(i)});
        chk("R1 full fill", 32'(fill_level), 64);
        chk("R10 no overrun yet", 32'(overrun), 0);
        do_wr(11'h7AA);
        chk("R10 overrun set", 32'(overrun), 1);
        chk("R10 fill after drop", 32'(fill_level), 64);
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
        chk("R10 overrun cleared", 32'(overrun), 0);
        for (int i = 0; i < 64; i++) begin
            chk("R1 order", 32'({head_err, rd_data}), 32'({3'(i % 8), 8'(i)}));
            do_rd();
            if (i == 15) begin
                @(negedge clk);
                chk("R8 hold at 48", 32'(rts_n), 1);
            end
            if (i == 22) begin
                @(negedge clk);
                chk("R8 hold at 41", 32'(rts_n), 1);
            end
            if (i == 23) begin
                @(negedge clk);
                chk("R8 rts_n at 40", 32'(rts_n), 0);
            end
        end
        chk("R1 drained, dropped write absent", 32'(fill_level), 0);

        // single-character mode
        do_reset();
        fifo_mode = 1'b0; flow_feat_en = 1'b0; flow_modem_en = 1'b0;
        do_wr(11'h3C1);
        chk("R4 irq per char", 32'(rx_ready_irq), 1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R5 irq gated", 32'(rx_ready_irq), 0);
        irq_en = 1'b1;
        do_wr(11'h055);
        chk("R4 capacity one", 32'(fill_level), 1);
        chk("R10 overrun single mode", 32'(overrun), 1);
        chk("R4 head kept", 32'({head_err, rd_data}), 32'(11'h3C1));
        do_rd();
        chk("R4 irq after read", 32'(rx_ready_irq), 0);

        // idle timeout
        do_reset();
        fifo_mode = 1'b1; trig_level = 7'd4; char_len = 2'd0; bit_tick = 1'b1;
        do_wr(11'h011);
        repeat (39) @(negedge clk);
        chk("R6 no timeout at 39 ticks", 32'(rx_tmo_irq), 0);
        @(negedge clk);
        chk("R6 timeout at 40 ticks", 32'(rx_tmo_irq), 1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R5 timeout gated", 32'(rx_tmo_irq), 0);
        irq_en = 1'b1;
        do_wr(11'h022);
        chk("R7 write restarts", 32'(rx_tmo_irq), 0);
        repeat (30) @(negedge clk);
        do_wr(11'h033);
        repeat (39) @(negedge clk);
        chk("R7 restart, 39 ticks", 32'(rx_tmo_irq), 0);
        @(negedge clk);
        chk("R7 restart, 40 ticks", 32'(rx_tmo_irq), 1);
        for (int i = 0; i < 3; i++) do_rd();
        repeat (100) @(negedge clk);
        chk("R7 empty no timeout", 32'(rx_tmo_irq), 0);
        char_len = 2'd3;
        do_wr(11'h044);
        repeat (51) @(negedge clk);
        chk("R6 len3 no timeout at 51", 32'(rx_tmo_irq), 0);
        @(negedge clk);
        chk("R6 len3 timeout at 52", 32'(rx_tmo_irq), 1);
        bit_tick = 1'b0;

        finish_run();
    end
endmodule